// File: doc/BRIEF.md
# Page-Mode DRAM Access Sequencer

This block sits between a synchronous requester and a 4-bit-wide asynchronous DRAM. It turns single-word read and write requests into strobe sequences on the DRAM pins. It multiplexes the row and column halves of the request address onto one shared address bus, and it captures read data from the DRAM at a safe point. Every minimum interval is given as a nanosecond parameter. Each one is turned into a clock count by rounding up against the clock-period parameter, so the same RTL serves any clock rate.

After an access the row stays open, with the row strobe held low. A later request to the same row is served by a column cycle alone, in which only the column strobe and the column address change. A request to another row closes the page first, and so does a row that has stayed open close to the longest allowed row-strobe low time. Closing a page means raising the row strobe and running the full precharge before the new row is opened. The request interface drops ready whenever a timing interval is still running, and whenever the request cannot be taken at once.

The state machine has six states. IDLE means no row is open and precharge is complete. ROWADDR holds the row strobe low with the row address on the bus until the row-to-column delay has passed. COLSTB holds the column strobe low for one read or write. COLPRE is the column-strobe precharge inside an open page. PAGE means a row is open and the block waits for a request. PRECHG holds the row strobe high for the precharge. The transitions are:
- IDLE→ROWADDR on an accepted request.
- ROWADDR→COLSTB when the delay ends.
- COLSTB→COLPRE when the pulse ends.
- COLPRE→PAGE when the precharge ends.
- PAGE→COLSTB on an accepted row hit.
- PAGE→PRECHG on a miss once the minimum row-strobe low time has been met, or when the page age limit is reached.
- PRECHG→IDLE when the precharge ends.

Top module: `fpm_dram_ctrl`

## Requirements
- R1: After reset, all four strobes (`dram_ras_n`, `dram_cas_n`, `dram_we_n`, `dram_oe_n`) are high, `req_ready` is 1 and `rsp_valid` is 0.
- R2: A request from IDLE lowers `dram_ras_n` with the row (upper ROW_W bits of `req_addr`) on `dram_addr`. The first `dram_cas_n` fall follows at least ceil(15 ns / period) and at most floor(35 ns / period) cycles later, with the column (lower COL_W bits) on `dram_addr`. The column strobe is low only while the row strobe is low.
- R3: `dram_ras_n` stays low for at least max(ceil(50/period), ceil(80/period) − ceil(30/period)) cycles, and stays high for at least ceil(30/period) cycles before it falls again.
- R4: A request to the row that is currently open is served by a column cycle alone. `dram_ras_n` stays low and does not fall again.
- R5: A request to a different row while a page is open makes `dram_ras_n` rise, runs the precharge, and then opens the new row with exactly one new `dram_ras_n` fall.
- R6: A read samples `dram_dq_in` only after max(ceil(12/period), ceil(25/period)) cycles of column strobe low. The data is returned on `rsp_data` with a one-cycle `rsp_valid` pulse, and reads complete in request order.
- R7: During a write column cycle, `dram_we_n` is low, `dram_dq_oe` is 1, `dram_oe_n` is high, and `dram_dq_out` carries the request data from the column-strobe fall onward. During a read column cycle, `dram_oe_n` is low, `dram_we_n` is high and `dram_dq_oe` is 0.
- R8: Between two column pulses in one page, `dram_cas_n` is high for at least ceil(8/period) cycles. It is high for at least one cycle before `dram_ras_n` rises.
- R9: `req_ready` is 0 in the cycle after any accepted request. It is also 0 while a page is open and the request is to a different row.
- R10: `dram_ras_n` never stays low for more than floor(10 µs / period) cycles. An idle open page is closed once its age reaches the page limit, with no request needed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request taken on this edge if valid |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | ROW_W+COL_W | Row in the upper bits, column in the lower bits |
| req_wdata | input | DQ_W | Write data |
| rsp_valid | output | 1 | One-cycle pulse with read data |
| rsp_data | output | DQ_W | Read data |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_oe_n | output | 1 | Output enable, active low |
| dram_addr | output | max(ROW_W,COL_W) | Multiplexed row/column address |
| dram_dq_out | output | DQ_W | Data driven toward the DRAM |
| dram_dq_oe | output | 1 | Drive enable for `dram_dq_out` |
| dram_dq_in | input | DQ_W | Data returned by the DRAM |

## Verification
The hardest condition to reach is the forced close of an open page on age, since it needs hundreds of cycles with a row held open and no request. The stimulus opens a row and then stays silent for longer than the page limit, and the bench measures the row-strobe low time. A second hard case is a row miss that arrives while a page is open and the minimum row-strobe low time has not yet passed. The bench drives that request straight after a hit and checks that ready stays low until precharge ends. The DRAM model in the bench returns inverted data until the column access time has elapsed, so a capture that comes too early shows up as a data mismatch.

// File: rtl/fpm_pkg.sv
`timescale 1ns/1ps
package fpm_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_ROWADDR,
        S_COLSTB,
        S_COLPRE,
        S_PAGE,
        S_PRECHG
    } fpm_state_e;

    // Round a nanosecond interval up to whole clock periods.
    function automatic int ns2cyc(input int ns, input int clk_ns);
        return (ns + clk_ns - 1) / clk_ns;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/fpm_span_timer.sv
`timescale 1ns/1ps
module fpm_span_timer #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] load_val_i,
    output logic         done_o
);

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= load_val_i;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign done_o = (cnt_q == '0);

endmodule

// File: rtl/fpm_row_tracker.sv
`timescale 1ns/1ps
module fpm_row_tracker #(
    parameter int ROW_W    = 12,
    parameter int AGE_W    = 10,
    parameter int LOW_MIN  = 5,
    parameter int AGE_STOP = 890
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             open_i,
    input  logic             close_i,
    input  logic [ROW_W-1:0] row_i,
    input  logic [ROW_W-1:0] cmp_row_i,
    output logic             hit_o,
    output logic             low_ok_o,
    output logic             age_stop_o,
    output logic [AGE_W-1:0] age_o
);

    localparam logic [AGE_W-1:0] LOW_M1 = AGE_W'(LOW_MIN - 1);
    localparam logic [AGE_W-1:0] STOP_V = AGE_W'(AGE_STOP);

    logic [ROW_W-1:0] row_q;
    logic             valid_q;
    logic [AGE_W-1:0] age_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            row_q   <= '0;
            valid_q <= 1'b0;
            age_q   <= '0;
        end else if (open_i) begin
            row_q   <= row_i;
            valid_q <= 1'b1;
            age_q   <= '0;
        end else if (close_i) begin
            valid_q <= 1'b0;
            age_q   <= '0;
        end else if (valid_q && (age_q != '1)) begin
            age_q <= age_q + 1'b1;
        end
    end

    assign hit_o      = valid_q && (row_q == cmp_row_i);
    assign low_ok_o   = (age_q >= LOW_M1);
    assign age_stop_o = valid_q && (age_q >= STOP_V);
    assign age_o      = age_q;

    // R5: a new row is opened only after the previous one was closed
    p_no_reopen_r5: assert property (@(posedge clk) disable iff (!rst_n)
        open_i |-> !valid_q);

endmodule

// File: rtl/fpm_rd_capture.sv
`timescale 1ns/1ps
module fpm_rd_capture #(
    parameter int DQ_W = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            take_i,
    input  logic [DQ_W-1:0] dq_i,
    output logic            valid_o,
    output logic [DQ_W-1:0] data_o
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_o <= 1'b0;
            data_o  <= '0;
        end else begin
            valid_o <= take_i;
            if (take_i) begin
                data_o <= dq_i;
            end
        end
    end

endmodule

// File: rtl/fpm_dram_ctrl.sv
`timescale 1ns/1ps
module fpm_dram_ctrl
    import fpm_pkg::*;
#(
    parameter int CLK_NS        = 10,
    parameter int ROW_W         = 12,
    parameter int COL_W         = 10,
    parameter int DQ_W          = 4,
    parameter int T_RCD_NS      = 15,
    parameter int T_RAS_NS      = 50,
    parameter int T_RAS_MAX_NS  = 10000,
    parameter int T_PAGE_LIM_NS = 9000,
    parameter int T_RP_NS       = 30,
    parameter int T_RC_NS       = 80,
    parameter int T_CAS_NS      = 8,
    parameter int T_CP_NS       = 8,
    parameter int T_CAC_NS      = 12,
    parameter int T_AA_NS       = 25,
    parameter int T_WCH_NS      = 10,
    parameter int T_DH_NS       = 8,
    parameter int T_RSH_NS      = 10,
    parameter int T_CRP_NS      = 5,
    localparam int ADDR_W       = (ROW_W > COL_W) ? ROW_W : COL_W
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   req_valid,
    output logic                   req_ready,
    input  logic                   req_we,
    input  logic [ROW_W+COL_W-1:0] req_addr,
    input  logic [DQ_W-1:0]        req_wdata,
    output logic                   rsp_valid,
    output logic [DQ_W-1:0]        rsp_data,
    output logic                   dram_ras_n,
    output logic                   dram_cas_n,
    output logic                   dram_we_n,
    output logic                   dram_oe_n,
    output logic [ADDR_W-1:0]      dram_addr,
    output logic [DQ_W-1:0]        dram_dq_out,
    output logic                   dram_dq_oe,
    input  logic [DQ_W-1:0]        dram_dq_in
);

    // Cycle counts derived from the nanosecond limits
    localparam int N_RCD      = imax(1, ns2cyc(T_RCD_NS, CLK_NS));
    localparam int N_RAS      = imax(1, ns2cyc(T_RAS_NS, CLK_NS));
    localparam int N_RP       = imax(1, ns2cyc(T_RP_NS, CLK_NS));
    localparam int N_RC       = ns2cyc(T_RC_NS, CLK_NS);
    localparam int N_CAS      = imax(1, ns2cyc(T_CAS_NS, CLK_NS));
    localparam int N_CP       = imax(1, ns2cyc(T_CP_NS, CLK_NS));
    localparam int N_ACC      = imax(ns2cyc(T_CAC_NS, CLK_NS), ns2cyc(T_AA_NS, CLK_NS));
    localparam int N_WCH      = ns2cyc(T_WCH_NS, CLK_NS);
    localparam int N_DH       = ns2cyc(T_DH_NS, CLK_NS);
    localparam int N_RSH      = ns2cyc(T_RSH_NS, CLK_NS);
    localparam int N_CRP      = imax(1, ns2cyc(T_CRP_NS, CLK_NS));
    localparam int N_RD_CAS   = imax(imax(N_CAS, N_ACC), N_RSH);
    localparam int N_WR_CAS   = imax(imax(N_CAS, N_RSH), imax(N_WCH, N_DH));
    localparam int N_COLPRE   = imax(N_CP, N_CRP);
    localparam int N_LOW_MIN  = imax(N_RAS, N_RC - N_RP);
    localparam int N_RAS_MAX  = T_RAS_MAX_NS / CLK_NS;
    localparam int N_PAGE_LIM = T_PAGE_LIM_NS / CLK_NS;
    localparam int N_AGE_STOP = N_PAGE_LIM - (imax(N_RD_CAS, N_WR_CAS) + N_COLPRE + 2);
    localparam int N_TMAX     = imax(imax(N_RCD, N_RP), imax(imax(N_RD_CAS, N_WR_CAS), N_COLPRE));
    localparam int TW         = $clog2(N_TMAX + 1);
    localparam int AGE_W      = $clog2(N_RAS_MAX + 2);

    fpm_state_e state_q, state_d;

    logic [ROW_W-1:0]  req_row;
    logic [COL_W-1:0]  req_col;
    logic              accept;
    logic              we_q;
    logic              we_sel;
    logic [COL_W-1:0]  col_q;
    logic [DQ_W-1:0]   wdata_q;
    logic [ADDR_W-1:0] addr_q;
    logic              tmr_load;
    logic [TW-1:0]     tmr_val;
    logic              tmr_done;
    logic              hit, low_ok, age_stop;
    logic [AGE_W-1:0]  age;
    logic              row_open, row_close, rd_take;

    assign req_row = req_addr[ROW_W+COL_W-1:COL_W];
    assign req_col = req_addr[COL_W-1:0];

    // Next state and request acceptance
    always_comb begin
        state_d   = state_q;
        req_ready = 1'b0;
        unique case (state_q)
            S_IDLE: begin
                req_ready = 1'b1;
                if (req_valid) state_d = S_ROWADDR;
            end
            S_ROWADDR: if (tmr_done) state_d = S_COLSTB;
            S_COLSTB:  if (tmr_done) state_d = S_COLPRE;
            S_COLPRE:  if (tmr_done) state_d = S_PAGE;
            S_PAGE: begin
                req_ready = hit && !age_stop;
                if (age_stop) begin
                    if (low_ok) state_d = S_PRECHG;
                end else if (req_valid && hit) begin
                    state_d = S_COLSTB;
                end else if (req_valid && low_ok) begin
                    state_d = S_PRECHG;
                end
            end
            S_PRECHG:  if (tmr_done) state_d = S_IDLE;
            default:   state_d = S_IDLE;
        endcase
    end

    assign accept = req_valid && req_ready;
    assign we_sel = (state_q == S_PAGE) ? req_we : we_q;

    // Interval length for the state being entered
    always_comb begin
        tmr_load = (state_d != state_q);
        case (state_d)
            S_ROWADDR: tmr_val = TW'(N_RCD - 1);
            S_COLSTB:  tmr_val = we_sel ? TW'(N_WR_CAS - 1) : TW'(N_RD_CAS - 1);
            S_COLPRE:  tmr_val = TW'(N_COLPRE - 1);
            S_PRECHG:  tmr_val = TW'(N_RP - 1);
            default:   tmr_val = '0;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // Request holding and address multiplexing
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            we_q    <= 1'b0;
            col_q   <= '0;
            wdata_q <= '0;
            addr_q  <= '0;
        end else if (accept) begin
            we_q    <= req_we;
            col_q   <= req_col;
            wdata_q <= req_wdata;
            addr_q  <= (state_q == S_IDLE) ? ADDR_W'(req_row) : ADDR_W'(req_col);
        end else if ((state_q == S_ROWADDR) && tmr_done) begin
            addr_q <= ADDR_W'(col_q);
        end
    end

    // Strobe outputs
    always_comb begin
        dram_ras_n = 1'b1;
        dram_cas_n = 1'b1;
        dram_we_n  = 1'b1;
        dram_oe_n  = 1'b1;
        dram_dq_oe = 1'b0;
        unique case (state_q)
            S_ROWADDR, S_COLPRE, S_PAGE: dram_ras_n = 1'b0;
            S_COLSTB: begin
                dram_ras_n = 1'b0;
                dram_cas_n = 1'b0;
                dram_we_n  = !we_q;
                dram_oe_n  = we_q;
                dram_dq_oe = we_q;
            end
            default: ;
        endcase
    end

    assign dram_addr   = addr_q;
    assign dram_dq_out = wdata_q;

    assign row_open  = (state_q == S_IDLE) && accept;
    assign row_close = (state_d == S_PRECHG) && (state_q != S_PRECHG);
    assign rd_take   = (state_q == S_COLSTB) && tmr_done && !we_q;

    fpm_span_timer #(.W(TW)) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (tmr_load),
        .load_val_i (tmr_val),
        .done_o     (tmr_done)
    );

    fpm_row_tracker #(
        .ROW_W    (ROW_W),
        .AGE_W    (AGE_W),
        .LOW_MIN  (N_LOW_MIN),
        .AGE_STOP (N_AGE_STOP)
    ) u_rows (
        .clk        (clk),
        .rst_n      (rst_n),
        .open_i     (row_open),
        .close_i    (row_close),
        .row_i      (req_row),
        .cmp_row_i  (req_row),
        .hit_o      (hit),
        .low_ok_o   (low_ok),
        .age_stop_o (age_stop),
        .age_o      (age)
    );

    fpm_rd_capture #(.DQ_W(DQ_W)) u_cap (
        .clk     (clk),
        .rst_n   (rst_n),
        .take_i  (rd_take),
        .dq_i    (dram_dq_in),
        .valid_o (rsp_valid),
        .data_o  (rsp_data)
    );

    // R2: column strobe only inside a row strobe
    p_cas_in_ras_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !dram_cas_n |-> !dram_ras_n);

    // R10: row strobe low time bounded
    p_ras_limit_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !dram_ras_n |-> (age < AGE_W'(N_RAS_MAX)));

    // R7: never write-enable and output-enable together
    p_we_oe_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !dram_we_n |-> dram_oe_n);

    // R9: an accepted request blocks the next one for at least a cycle
    p_busy_after_accept_r9: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> !req_ready);

    // R4: a hit taken while the row is open keeps the row strobe low
    p_hit_keeps_row_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !dram_ras_n) |=> (!dram_ras_n && !dram_cas_n));

    // R6: read data only follows a read column cycle
    p_rsp_after_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(!dram_oe_n && !dram_cas_n));

endmodule

// File: tb/tb_fpm_dram_ctrl.sv
`timescale 1ns/1ps
module tb_fpm_dram_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int ROW_W = 12;
    localparam int COL_W = 10;
    localparam int RCD_MIN_C = (15 + CLK_PERIOD - 1) / CLK_PERIOD;
    localparam int RCD_MAX_C = 35 / CLK_PERIOD;
    localparam int RP_C      = (30 + CLK_PERIOD - 1) / CLK_PERIOD;
    localparam int RAS_C     = (50 + CLK_PERIOD - 1) / CLK_PERIOD;
    localparam int RC_C      = (80 + CLK_PERIOD - 1) / CLK_PERIOD;
    localparam int LOWMIN_C  = (RAS_C > RC_C - RP_C) ? RAS_C : RC_C - RP_C;
    localparam int CP_C      = (8 + CLK_PERIOD - 1) / CLK_PERIOD;
    localparam int ACC_C     = (25 + CLK_PERIOD - 1) / CLK_PERIOD;
    localparam int RASMAX_C  = 10000 / CLK_PERIOD;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic req_ready;
    logic req_we = 1'b0;
    logic [ROW_W+COL_W-1:0] req_addr = '0;
    logic [3:0] req_wdata = '0;
    logic rsp_valid;
    logic [3:0] rsp_data;
    logic dram_ras_n, dram_cas_n, dram_we_n, dram_oe_n, dram_dq_oe;
    logic [11:0] dram_addr;
    logic [3:0] dram_dq_out;
    logic [3:0] dram_dq_in = 4'hF;

    always #(CLK_PERIOD / 2) clk = ~clk;

    fpm_dram_ctrl #(.CLK_NS(CLK_PERIOD)) dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_we(req_we),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data),
        .dram_ras_n(dram_ras_n), .dram_cas_n(dram_cas_n),
        .dram_we_n(dram_we_n), .dram_oe_n(dram_oe_n),
        .dram_addr(dram_addr), .dram_dq_out(dram_dq_out),
        .dram_dq_oe(dram_dq_oe), .dram_dq_in(dram_dq_in)
    );

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    logic [3:0] dmem [int];   // DRAM model contents
    logic [3:0] rmem [int];   // reference contents
    int aq_row [$];
    int aq_col [$];
    logic [3:0] sq [$];       // expected read data
    int ras_falls = 0;

    function automatic logic [3:0] dflt(input int key);
        return 4'(key) ^ 4'(key >> 10) ^ 4'h6;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    // Driver: presents one request, records expected results at acceptance
    task automatic issue(input bit we, input int row, input int col,
                         input logic [3:0] d, input bit expect_block);
        int key;
        key = row * 1024 + col;
        @(negedge clk);
        req_valid = 1'b1;
        req_we    = we;
        req_addr  = {ROW_W'(row), COL_W'(col)};
        req_wdata = d;
        #1;
        if (expect_block) chk(req_ready == 1'b0, "R9 miss blocked", int'(req_ready), 0);
        while (!req_ready) begin
            @(negedge clk);
            #1;
        end
        @(posedge clk);
        aq_row.push_back(row);
        aq_col.push_back(col);
        if (we) rmem[key] = d;
        else sq.push_back(rmem.exists(key) ? rmem[key] : dflt(key));
        #1;
        req_valid = 1'b0;
        chk(req_ready == 1'b0, "R9 ready after accept", int'(req_ready), 0);
    endtask

    task automatic drain();
        while (sq.size() != 0 || aq_row.size() != 0) @(negedge clk);
        repeat (4) @(negedge clk);
    endtask

    // Monitor: DRAM model, timing checks, scoreboard
    bit ras_p = 1, cas_p = 1, have_rise = 0, first_cas = 0;
    int ras_low_cyc = 0, ras_hi_cyc = 0, cas_hi_cyc = 0, cas_low_k = 0;
    int lat_row = 0, lat_col = 0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (!dram_ras_n && ras_p) begin
                ras_falls++;
                if (have_rise) chk(ras_hi_cyc >= RP_C, "R3 precharge", ras_hi_cyc, RP_C);
                lat_row = int'(dram_addr);
                if (aq_row.size() > 0) chk(lat_row == aq_row[0], "R2 row addr", lat_row, aq_row[0]);
                first_cas = 1;
            end
            if (dram_ras_n && !ras_p) begin
                chk(ras_low_cyc >= LOWMIN_C, "R3 ras low min", ras_low_cyc, LOWMIN_C);
                chk(ras_low_cyc <= RASMAX_C, "R10 ras low max", ras_low_cyc, RASMAX_C);
                chk(cas_hi_cyc >= 1, "R8 cas high before ras rise", cas_hi_cyc, 1);
                have_rise = 1;
            end
            if (!dram_cas_n && cas_p) begin
                lat_col = int'(dram_addr);
                if (aq_col.size() > 0) begin
                    chk(lat_col == aq_col[0], "R2 col addr", lat_col, aq_col[0]);
                    void'(aq_col.pop_front());
                    void'(aq_row.pop_front());
                end else begin
                    chk(0, "R2 column cycle without request", 1, 0);
                end
                if (first_cas) begin
                    chk(ras_low_cyc >= RCD_MIN_C && ras_low_cyc <= RCD_MAX_C,
                        "R2 ras-to-cas delay", ras_low_cyc, RCD_MIN_C);
                end else begin
                    chk(cas_hi_cyc >= CP_C, "R8 cas precharge", cas_hi_cyc, CP_C);
                end
                first_cas = 0;
                if (!dram_we_n) begin
                    chk(dram_dq_oe && dram_oe_n, "R7 write strobes", int'(dram_dq_oe), 1);
                    dmem[lat_row * 1024 + lat_col] = dram_dq_out;
                end
            end
            if (!dram_cas_n && !dram_oe_n)
                chk(dram_we_n && !dram_dq_oe, "R7 read strobes", int'(dram_we_n), 1);
            if (rsp_valid) begin
                if (sq.size() == 0) chk(0, "R6 unexpected response", int'(rsp_data), -1);
                else begin
                    logic [3:0] e;
                    e = sq.pop_front();
                    chk(rsp_data == e, "R6 read data", int'(rsp_data), int'(e));
                end
            end
        end
        ras_low_cyc = dram_ras_n ? 0 : ras_low_cyc + 1;
        ras_hi_cyc  = dram_ras_n ? ras_hi_cyc + 1 : 0;
        cas_hi_cyc  = dram_cas_n ? cas_hi_cyc + 1 : 0;
        cas_low_k   = dram_cas_n ? 0 : cas_low_k + 1;
        if (!dram_cas_n && !dram_oe_n) begin
            int key;
            logic [3:0] v;
            key = lat_row * 1024 + lat_col;
            v = dmem.exists(key) ? dmem[key] : dflt(key);
            dram_dq_in = (cas_low_k >= ACC_C) ? v : ~v;
        end else begin
            dram_dq_in = 4'hF;
        end
        ras_p = dram_ras_n;
        cas_p = dram_cas_n;
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        int f0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(dram_ras_n && dram_cas_n && dram_we_n && dram_oe_n, "R1 strobes idle",
            int'({dram_ras_n, dram_cas_n, dram_we_n, dram_oe_n}), 15);
        chk(req_ready == 1'b1, "R1 ready", int'(req_ready), 1);
        chk(rsp_valid == 1'b0, "R1 no response", int'(rsp_valid), 0);

        // R4 page hits: writes and reads in one row
        f0 = ras_falls;
        issue(1, 5, 3, 4'hA, 0);
        issue(1, 5, 4, 4'h5, 0);
        issue(0, 5, 3, 4'h0, 0);
        issue(0, 5, 4, 4'h0, 0);
        issue(0, 5, 900, 4'h0, 0);
        drain();
        chk(ras_falls - f0 == 1, "R4 single row open", ras_falls - f0, 1);

        // R5 row miss while page open, R9 miss blocked
        f0 = ras_falls;
        issue(0, 9, 3, 4'h0, 1);
        drain();
        chk(ras_falls - f0 == 1, "R5 reopen count", ras_falls - f0, 1);

        // R9 miss immediately after a hit (minimum low time pending)
        issue(1, 9, 7, 4'hC, 0);
        issue(0, 5, 3, 4'h0, 1);
        issue(0, 9, 7, 4'h0, 1);
        drain();

        // Back-to-back hit burst, R6 order, R8 precharge
        f0 = ras_falls;
        for (int i = 0; i < 6; i++) issue(i[0], 9, 20 + i, 4'(i + 3), 0);
        for (int i = 0; i < 6; i++) issue(0, 9, 20 + i, 4'h0, 0);
        drain();
        chk(ras_falls - f0 == 0, "R4 burst stays in page", ras_falls - f0, 0);

        // R10 idle page closes on age
        repeat (RASMAX_C + 100) @(negedge clk);
        chk(dram_ras_n == 1'b1, "R10 idle page closed", int'(dram_ras_n), 1);
        chk(req_ready == 1'b1, "R10 ready after close", int'(req_ready), 1);

        // Row 4095 corner, then read back across rows
        issue(1, 4095, 1023, 4'h9, 0);
        issue(0, 5, 4, 4'h0, 0);
        issue(0, 4095, 1023, 4'h0, 0);
        drain();
        chk(sq.size() == 0, "R6 all responses returned", sq.size(), 0);
        finish_run();
    end

endmodule